// File: doc/BRIEF.md
# Flag-Generating Byte ALU

This block is the arithmetic and logic core for an 8-bit accumulator datapath. One operation code picks the work done on two byte operands: the register operand (`reg_i`) and the memory operand (`mem_i`). The block also takes the incoming status flags: Negative, oVerflow, Zero and Carry. It returns the byte result combinationally, in the same cycle. It also computes the updated flag set, which it captures in a register on every clock edge so the surrounding datapath can use it in the next cycle.

Each operation has fixed rules on which flags it may write. The adder computes add, subtract, compare and the signed-overflow test. Flags that an operation does not define are copied from the incoming flags unchanged. Arithmetic is always binary.

Shifts, rotates, increment and decrement act on the memory operand, as a read-modify-write unit would. Compare, bit test and the unassigned codes return the register operand unchanged as the result.

Top module: `alu_flagger`

## Requirements
- R1: ADD (op 0) gives `res_o` = low 8 bits of reg + mem + Cin, where Cin is `flags_i[0]`. The next C is bit 8 of that 9-bit sum.
- R2: SUB (op 1) is complement-add: `res_o` = low 8 bits of reg + (~mem) + Cin. The next C is bit 8 of that sum, so C=1 means no borrow.
- R3: For ADD and SUB, the next V is bit 7 of (reg ^ res) & (opnd ^ res). Here opnd is mem for ADD and ~mem for SUB.
- R4: CMP (op 5) forms reg - mem with no carry in. The next C is 1 exactly when reg >= mem unsigned, and N and Z come from the low byte of the difference. V is unchanged and `res_o` equals reg.
- R5: BIT (op 6) sets the next N from mem bit 7, V from mem bit 6, and Z when (reg & mem) is zero. C is unchanged and `res_o` equals reg.
- R6: On mem: SHL (op 7) moves bit 7 into C and shifts in 0. SHR (op 8) moves bit 0 into C and shifts in 0. ROL (op 9) and ROR (op 10) move the outgoing bit into C and bring the old C into the vacated bit.
- R7: INC (op 11) and DEC (op 12) give mem + 1 and mem - 1 modulo 256. They write only N and Z, so V and C are copied from `flags_i`.
- R8: Every result-producing op (0-4, 7-12) sets the next N to `res_o` bit 7 and Z when `res_o` is zero.
- R9: AND (op 2), XOR (op 3) and OR (op 4) combine reg with mem and keep V and C.
- R10: Unassigned codes 13-15 give `res_o` = reg and next flags equal to `flags_i`.
- R11: `flags_q_o` holds the next-flag value chosen in the previous cycle, with bit 3=N, bit 2=V, bit 1=Z, bit 0=C. It reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| op_i | input | 4 | Operation code |
| reg_i | input | 8 | Register operand |
| mem_i | input | 8 | Memory operand |
| flags_i | input | 4 | Incoming flags {N,V,Z,C} |
| res_o | output | 8 | Combinational result |
| flags_q_o | output | 4 | Registered updated flags {N,V,Z,C} |

## Verification
The assertions compare the flag register with the inputs held in the previous cycle. They therefore assume that `op_i`, the operands and `flags_i` are steady across each rising edge and carry known values once reset is released. The stimulus changes every input only on the falling clock edge, and only after reset has been released on a falling edge. It walks all sixteen codes, including the unassigned ones. It also feeds the operand corners that decide carry, borrow, overflow and zero: 0x00, 0x7F, 0x80 and 0xFF, with the carry-in both set and clear.

// File: rtl/alu_flagger_pkg.sv
package alu_flagger_pkg;
  localparam int FLAG_W = 4;
  localparam int FN = 3;
  localparam int FV = 2;
  localparam int FZ = 1;
  localparam int FC = 0;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_AND = 4'd2;
  localparam logic [3:0] OP_XOR = 4'd3;
  localparam logic [3:0] OP_OR  = 4'd4;
  localparam logic [3:0] OP_CMP = 4'd5;
  localparam logic [3:0] OP_BIT = 4'd6;
  localparam logic [3:0] OP_SHL = 4'd7;
  localparam logic [3:0] OP_SHR = 4'd8;
  localparam logic [3:0] OP_ROL = 4'd9;
  localparam logic [3:0] OP_ROR = 4'd10;
  localparam logic [3:0] OP_INC = 4'd11;
  localparam logic [3:0] OP_DEC = 4'd12;

  typedef enum logic [1:0] {LG_AND = 2'd0, LG_XOR = 2'd1, LG_OR = 2'd2} logic_sel_e;
  typedef enum logic [2:0] {
    SH_SHL = 3'd0, SH_SHR = 3'd1, SH_ROL = 3'd2, SH_ROR = 3'd3,
    SH_INC = 3'd4, SH_DEC = 3'd5
  } shift_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int SW = W + 1;

  function automatic logic [SW-1:0] f_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  function automatic logic f_ovf(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic [W-1:0] s);
    logic [W-1:0] t;
    t = (a ^ s) & (b ^ s);
    return t[W-1];
  endfunction

  logic [W-1:0]  b_eff;
  logic [SW-1:0] wide;

  assign b_eff  = inv_i ? ~b_i : b_i;
  assign wide   = f_add(a_i, b_eff, cin_i);
  assign sum_o  = wide[W-1:0];
  assign cout_o = wide[W];
  assign ovf_o  = f_ovf(a_i, b_eff, wide[W-1:0]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_flagger_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] y_o,
  output logic         mask_zero_o
);
  function automatic logic [W-1:0] f_logic(input logic_sel_e s, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (s)
      LG_AND:  return a & b;
      LG_XOR:  return a ^ b;
      default: return a | b;
    endcase
  endfunction

  assign y_o         = f_logic(sel_i, a_i, b_i);
  assign mask_zero_o = ~|(a_i & b_i);
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_flagger_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] v_i,
  input  logic         cin_i,
  input  shift_sel_e   sel_i,
  output logic [W-1:0] y_o,
  output logic         cout_o
);
  function automatic logic [W:0] f_shift(input shift_sel_e s, input logic [W-1:0] v,
                                         input logic c);
    case (s)
      SH_SHL:  return {v[W-1], v[W-2:0], 1'b0};
      SH_SHR:  return {v[0], 1'b0, v[W-1:1]};
      SH_ROL:  return {v[W-1], v[W-2:0], c};
      SH_ROR:  return {v[0], c, v[W-1:1]};
      SH_INC:  return {c, v + {{(W-1){1'b0}}, 1'b1}};
      SH_DEC:  return {c, v - {{(W-1){1'b0}}, 1'b1}};
      default: return {c, v};
    endcase
  endfunction

  logic [W:0] packed_out;
  assign packed_out = f_shift(sel_i, v_i, cin_i);
  assign y_o        = packed_out[W-1:0];
  assign cout_o     = packed_out[W];
endmodule

// File: rtl/alu_flagger.sv
module alu_flagger
  import alu_flagger_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      reg_i,
  input  logic [W-1:0]      mem_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [W-1:0]      res_o,
  output logic [FLAG_W-1:0] flags_q_o
);
  localparam int MSB = W - 1;

  // adder: ADD, SUB and CMP share one complement-add
  logic [W-1:0] add_sum;
  logic         add_cout, add_ovf, add_inv, add_cin;
  assign add_inv = (op_i == OP_SUB) || (op_i == OP_CMP);
  assign add_cin = (op_i == OP_CMP) ? 1'b1 : flags_i[FC];

  alu_addsub #(.W(W)) u_addsub (
    .a_i(reg_i), .b_i(mem_i), .inv_i(add_inv), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  logic_sel_e   lg_sel;
  logic [W-1:0] lg_y;
  logic         lg_mask_zero;
  always_comb begin
    case (op_i)
      OP_AND:  lg_sel = LG_AND;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_OR;
    endcase
  end

  alu_logic #(.W(W)) u_logic (
    .a_i(reg_i), .b_i(mem_i), .sel_i(lg_sel), .y_o(lg_y), .mask_zero_o(lg_mask_zero)
  );

  shift_sel_e   sh_sel;
  logic [W-1:0] sh_y;
  logic         sh_cout;
  always_comb begin
    case (op_i)
      OP_SHL:  sh_sel = SH_SHL;
      OP_SHR:  sh_sel = SH_SHR;
      OP_ROL:  sh_sel = SH_ROL;
      OP_ROR:  sh_sel = SH_ROR;
      OP_INC:  sh_sel = SH_INC;
      default: sh_sel = SH_DEC;
    endcase
  end

  alu_shift #(.W(W)) u_shift (
    .v_i(mem_i), .cin_i(flags_i[FC]), .sel_i(sh_sel), .y_o(sh_y), .cout_o(sh_cout)
  );

  // result and flag selection
  logic [W-1:0]      res_c;
  logic [FLAG_W-1:0] nxt_flags;
  logic              nz_from_res;

  always_comb begin
    res_c       = reg_i;
    nxt_flags   = flags_i;
    nz_from_res = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        res_c         = add_sum;
        nxt_flags[FC] = add_cout;
        nxt_flags[FV] = add_ovf;
        nz_from_res   = 1'b1;
      end
      OP_AND, OP_XOR, OP_OR: begin
        res_c       = lg_y;
        nz_from_res = 1'b1;
      end
      OP_CMP: begin
        nxt_flags[FC] = add_cout;
        nxt_flags[FN] = add_sum[MSB];
        nxt_flags[FZ] = ~|add_sum;
      end
      OP_BIT: begin
        nxt_flags[FN] = mem_i[MSB];
        nxt_flags[FV] = mem_i[MSB-1];
        nxt_flags[FZ] = lg_mask_zero;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_c         = sh_y;
        nxt_flags[FC] = sh_cout;
        nz_from_res   = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_c       = sh_y;
        nz_from_res = 1'b1;
      end
      default: ;
    endcase
    if (nz_from_res) begin
      nxt_flags[FN] = res_c[MSB];
      nxt_flags[FZ] = ~|res_c;
    end
  end

  assign res_o = res_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q_o <= '0;
    else        flags_q_o <= nxt_flags;
  end

  // assertions
  p_add_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD) |->
      (add_ovf == ((reg_i[MSB] == mem_i[MSB]) && (res_o[MSB] != reg_i[MSB]))));

  p_cmp_reg_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP || op_i == OP_BIT) |-> (res_o == reg_i));

  p_cmp_keeps_v_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |=> (flags_q_o[FV] == $past(flags_i[FV])));

  p_bit_nv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BIT) |=>
      (flags_q_o[FN] == $past(mem_i[MSB]) && flags_q_o[FV] == $past(mem_i[MSB-1])));

  p_incdec_vc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_INC || op_i == OP_DEC) |=>
      (flags_q_o[FV] == $past(flags_i[FV]) && flags_q_o[FC] == $past(flags_i[FC])));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i <= OP_OR || (op_i >= OP_SHL && op_i <= OP_DEC)) |=>
      (flags_q_o[FZ] == ($past(res_o) == '0)));

  p_undef_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > OP_DEC) |=> (flags_q_o == $past(flags_i)));
endmodule

// File: tb/alu_flagger_test.sv
`timescale 1ns/1ps
module alu_flagger_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] reg_i = '0, mem_i = '0;
  logic [3:0] flags_i = '0;
  logic [7:0] res_o;
  logic [3:0] flags_q_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu_flagger uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .reg_i(reg_i), .mem_i(mem_i),
    .flags_i(flags_i), .res_o(res_o), .flags_q_o(flags_q_o)
  );

  function automatic string req_of(int op);
    case (op)
      0: return "R1/R3/R8";
      1: return "R2/R3/R8";
      2, 3, 4: return "R9/R8";
      5: return "R4";
      6: return "R5";
      7, 8, 9, 10: return "R6/R8";
      11, 12: return "R7/R8";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference using integers
  task automatic model(input int op, input int r, input int m, input int f,
                       output int res, output int nf);
    int n, v, z, c, s, mm;
    n = (f >> 3) & 1; v = (f >> 2) & 1; z = (f >> 1) & 1; c = f & 1;
    res = r;
    case (op)
      0, 1: begin
        mm  = (op == 1) ? (255 - m) : m;
        s   = r + mm + c;
        res = s % 256;
        c   = (s >= 256) ? 1 : 0;
        v   = (((r ^ res) & (mm ^ res)) >= 128 || (((r ^ res) & (mm ^ res)) & 128) != 0) ? 1 : 0;
      end
      2: res = r & m;
      3: res = r ^ m;
      4: res = r | m;
      5: begin
        s = r - m;
        if (s < 0) s = s + 256;
        c = (r >= m) ? 1 : 0;
        n = (s >= 128) ? 1 : 0;
        z = (s == 0) ? 1 : 0;
      end
      6: begin
        n = (m >= 128) ? 1 : 0;
        v = ((m % 128) >= 64) ? 1 : 0;
        z = ((r & m) == 0) ? 1 : 0;
      end
      7: begin res = (m * 2) % 256; c = m / 128; end
      8: begin res = m / 2; c = m % 2; end
      9: begin res = (m * 2) % 256 + c; c = m / 128; end
      10: begin res = m / 2 + c * 128; c = m % 2; end
      11: res = (m + 1) % 256;
      12: res = (m + 255) % 256;
      default: ;
    endcase
    if (op <= 4 || (op >= 7 && op <= 12)) begin
      n = (res >= 128) ? 1 : 0;
      z = (res == 0) ? 1 : 0;
    end
    nf = n * 8 + v * 4 + z * 2 + c;
  endtask

  task automatic apply(input int op, input int r, input int m, input int f);
    int er, ef;
    @(negedge clk);
    op_i = op[3:0]; reg_i = r[7:0]; mem_i = m[7:0]; flags_i = f[3:0];
    model(op, r, m, f, er, ef);
    #1;
    compared++;
    if (int'(res_o) != er) begin
      mismatched++;
      $display("FAIL %s res op=%0d r=%02h m=%02h f=%h: actual %02h expected %02h",
               req_of(op), op, r, m, f, res_o, er);
    end
    @(posedge clk); #1;
    compared++;
    if (int'(flags_q_o) != ef) begin
      mismatched++;
      $display("FAIL %s/R11 flags op=%0d r=%02h m=%02h f=%h: actual %h expected %h",
               req_of(op), op, r, m, f, flags_q_o, ef);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired: actual running expected finished");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compared++; // R11 reset value
    if (flags_q_o !== 4'h0) begin
      mismatched++;
      $display("FAIL R11 reset flags: actual %h expected 0", flags_q_o);
    end
    @(negedge clk);
    flags_i = 4'hF;
    rst_n = 1'b1;

    // R1 carry out and R3 signed overflow corners
    apply(0, 8'hFF, 8'h01, 0);
    apply(0, 8'h7F, 8'h01, 0);
    apply(0, 8'h80, 8'h80, 1);
    apply(0, 8'h00, 8'h00, 1);
    // R2 complement-add subtract
    apply(1, 8'h00, 8'h01, 1);
    apply(1, 8'h80, 8'h01, 1);
    apply(1, 8'h50, 8'h50, 0);
    // R4 compare equal, less, greater
    apply(5, 8'h40, 8'h40, 4'h4);
    apply(5, 8'h10, 8'h20, 4'h0);
    apply(5, 8'hFF, 8'h00, 4'h0);
    // R5 bit test
    apply(6, 8'h0F, 8'hC0, 4'h1);
    apply(6, 8'hFF, 8'h41, 4'h0);
    // R6 shift/rotate with carry in set and clear
    for (int op = 7; op <= 10; op++) begin
      apply(op, 8'h00, 8'h81, 1);
      apply(op, 8'h00, 8'h80, 0);
      apply(op, 8'h00, 8'h01, 1);
    end
    // R7 wrap
    apply(11, 8'h00, 8'hFF, 4'h5);
    apply(12, 8'h00, 8'h00, 4'h5);
    apply(12, 8'h00, 8'h01, 4'h0);
    // R9 logic keeps V and C
    apply(2, 8'hF0, 8'h0F, 4'h5);
    apply(3, 8'hAA, 8'hAA, 4'h4);
    apply(4, 8'h00, 8'h80, 4'h1);
    // R10 unassigned codes
    for (int op = 13; op <= 15; op++) apply(op, 8'h3C, 8'hC3, 4'hA);

    for (int i = 0; i < 3000; i++)
      apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 15)));
    report();
  end
endmodule